// File: doc/BRIEF.md
# Component Video Byte-Stream Demultiplexer

The block takes an 8-bit component video stream that carries one byte per clock. Within active video the bytes repeat as Cb, Y, Cr, Y. The block splits this stream into pixels, each with one luma sample and the shared chroma pair, and marks them with a valid strobe. Two pixels come out for every four input bytes, so the average pixel rate is half the byte clock. The block also recovers the line and field timing as three registered flags: horizontal blanking, vertical blanking and field.

Timing can come from two sources, chosen by a 2-bit source select. In embedded mode the block watches the stream for a timing reference: three preamble bytes (all ones, then two all-zero bytes) followed by a status byte. The status byte supplies the flags and marks where active video starts and ends. In external mode the block ignores any codes in the stream. It takes its timing from a horizontal and a vertical strobe instead, and opens a line on the falling edge of the horizontal strobe. The remaining select codes switch the block off.

Top module: `vid_stream_demux`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, and for the two clocks after it is released, every output reads zero. Release takes effect on the third rising edge after reset goes high.
- R2: The source select is decoded as follows: 2'b00 is embedded timing, 2'b01 is external strobes, and 2'b10 or 2'b11 is off. When off, any capture in progress stops, the valid strobe stays low and all three flags keep their values.
- R3: In embedded mode, a timing code is recognised when bytes 0xFF, 0x00, 0x00 are followed by a status byte whose bit 7 is 1. At the edge that samples the status byte, the flags load field from bit 6, vertical from bit 5 and horizontal from bit 4. A status byte with bit 7 equal to 0 changes nothing.
- R4: A start-of-line code opens capture. This is a recognised code with bit 4 = 0 and bit 5 = 0. The next byte is then taken as Cb, followed by Y, Cr and Y. A code with bit 5 = 1 opens no capture.
- R5: At the edge that samples the Cr byte, the outputs show the first Y, Cb and Cr, with valid high. At the edge that samples the second Y, they show that Y with the same Cb and Cr, again with valid high. In every other cycle valid is low and the sample outputs hold their values.
- R6: In embedded mode, a 0xFF byte during capture ends capture. Code bytes are never emitted, and an unfinished group that lacks its Cr byte produces no pixel.
- R7: In external mode, the horizontal and vertical flags follow the two strobes one clock later. The field flag toggles on every rising edge of the vertical strobe.
- R8: In external mode, a falling edge of the horizontal strobe opens capture, and the byte that arrives with the edge is discarded. The next byte is taken as Cb. A rising edge of the horizontal strobe ends capture, and the byte that arrives with that edge is not used.
- R9: In external mode, a timing code inside the byte stream has no effect on the flags.
- R10: In external mode, a falling edge of the horizontal strobe while the vertical strobe is high opens no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Multiplexed component byte |
| src_mode | input | 2 | Timing source: 00 embedded, 01 external, 1x off |
| hs_in | input | 1 | External horizontal strobe, high in blanking |
| vs_in | input | 1 | External vertical strobe, high in blanking |
| y_out | output | 8 | Luma sample |
| cb_out | output | 8 | Blue-difference sample |
| cr_out | output | 8 | Red-difference sample |
| pix_valid | output | 1 | One-cycle strobe per emitted pixel |
| h_flag | output | 1 | Horizontal blanking flag |
| v_flag | output | 1 | Vertical blanking flag |
| f_flag | output | 1 | Field flag |

## Verification
Embedded lines use differing sample values in every byte position, so a swap of Cb and Cr, of the two Y samples, or a phase slip shows up directly. Several status bytes test the flag bit positions and the role of bit 7: end-of-line, start-of-line, vertical blanking, second field, and a status byte with bit 7 cleared. A line cut off in mid-group shows whether the block emits partial pixels. In external mode, strobe edges that fall on different group phases, a timing code placed in the data, and a horizontal edge while the vertical strobe is high separate the two timing paths from each other. Switching the select to off shows whether the outputs freeze.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  // Timing source select (R2)
  typedef enum logic [1:0] {
    SRC_EMBED = 2'b00,
    SRC_EXT   = 2'b01,
    SRC_OFF_A = 2'b10,
    SRC_OFF_B = 2'b11
  } src_sel_e;

  // Position inside a Cb,Y,Cr,Y group (R4, R5)
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tflags_t;

endpackage

// File: rtl/vsd_trs_detect.sv
module vsd_trs_detect
  import vsd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              hit,
  output tflags_t           code_flags,
  output logic              lead_byte
);

  localparam int F_BIT = DATA_W - 2;
  localparam int V_BIT = DATA_W - 3;
  localparam int H_BIT = DATA_W - 4;
  localparam logic [DATA_W-1:0] ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZEROS = {DATA_W{1'b0}};

  logic [DATA_W-1:0] hist_q [PRE_LEN];
  logic [DATA_W-1:0] hist_d [PRE_LEN];
  logic [PRE_LEN-1:0] stage_ok;

  // Shift history: stage 0 is the newest byte, the last stage the oldest.
  generate
    for (genvar g = 0; g < PRE_LEN; g++) begin : g_hist
      if (g == 0) begin : g_head
        assign hist_d[g] = din;
      end else begin : g_tail
        assign hist_d[g] = hist_q[g-1];
      end
      if (g == PRE_LEN - 1) begin : g_lead
        assign stage_ok[g] = (hist_q[g] == ONES);
      end else begin : g_zero
        assign stage_ok[g] = (hist_q[g] == ZEROS);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= ZEROS;
    end else begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= hist_d[i];
    end
  end

  // R3: status byte must carry a set top bit
  always_comb begin
    hit          = (&stage_ok) & din[DATA_W-1];
    code_flags.f = din[F_BIT];
    code_flags.v = din[V_BIT];
    code_flags.h = din[H_BIT];
    lead_byte    = (din == ONES);
  end

endmodule

// File: rtl/vsd_ext_sync.sv
module vsd_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_in,
  input  logic vs_in,
  output logic hs_fall,
  output logic hs_rise,
  output logic vs_rise
);

  logic hs_q, vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hs_in;
      vs_q <= vs_in;
    end
  end

  always_comb begin
    hs_fall = hs_q & ~hs_in;
    hs_rise = ~hs_q & hs_in;
    vs_rise = ~vs_q & vs_in;
  end

endmodule

// File: rtl/vsd_pixel_pack.sv
module vsd_pixel_pack
  import vsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              start,
  input  logic              stop,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] cb_out,
  output logic [DATA_W-1:0] cr_out,
  output logic              valid
);

  logic              active_q, active_d;
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] cb_q, cb_d, y0_q, y0_d;
  logic [DATA_W-1:0] y_q, y_d, cbo_q, cbo_d, cro_q, cro_d;
  logic              valid_q, valid_d;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    cb_d     = cb_q;
    y0_d     = y0_q;
    y_d      = y_q;
    cbo_d    = cbo_q;
    cro_d    = cro_q;
    valid_d  = 1'b0;
    if (start) begin
      active_d = 1'b1;              // R4, R8: next byte is Cb
      phase_d  = PH_CB;
    end else if (stop) begin
      active_d = 1'b0;              // R6, R8: this byte is dropped
    end else if (active_q) begin
      phase_d = phase_e'(phase_q + 2'd1);
      unique case (phase_q)
        PH_CB: cb_d = din;
        PH_Y0: y0_d = din;
        PH_CR: begin                // R5: first pixel of the pair
          y_d     = y0_q;
          cbo_d   = cb_q;
          cro_d   = din;
          valid_d = 1'b1;
        end
        PH_Y1: begin                // R5: second pixel shares chroma
          y_d     = din;
          valid_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_CB;
      cb_q     <= '0;
      y0_q     <= '0;
      y_q      <= '0;
      cbo_q    <= '0;
      cro_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      cb_q     <= cb_d;
      y0_q     <= y0_d;
      y_q      <= y_d;
      cbo_q    <= cbo_d;
      cro_q    <= cro_d;
      valid_q  <= valid_d;
    end
  end

  assign y_out  = y_q;
  assign cb_out = cbo_q;
  assign cr_out = cro_q;
  assign valid  = valid_q;

endmodule

// File: rtl/vid_stream_demux.sv
module vid_stream_demux
  import vsd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_LEN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        src_mode,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] cb_out,
  output logic [DATA_W-1:0] cr_out,
  output logic              pix_valid,
  output logic              h_flag,
  output logic              v_flag,
  output logic              f_flag
);

  // R1: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  // R2: source decode
  src_sel_e src;
  logic     use_embed, use_ext, src_off;
  assign src       = src_sel_e'(src_mode);
  assign use_embed = (src == SRC_EMBED);
  assign use_ext   = (src == SRC_EXT);
  assign src_off   = src_mode[1];

  logic    code_hit, lead_byte;
  tflags_t code_flags;
  logic    hs_fall, hs_rise, vs_rise;
  logic    cap_start, cap_stop;

  vsd_trs_detect #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) trs_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .din        (din),
    .hit        (code_hit),
    .code_flags (code_flags),
    .lead_byte  (lead_byte)
  );

  vsd_ext_sync ext_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hs_in   (hs_in),
    .vs_in   (vs_in),
    .hs_fall (hs_fall),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise)
  );

  // R4, R10: opening a line; R6, R8, R2: closing it
  assign cap_start = (use_embed & code_hit & ~code_flags.h & ~code_flags.v)
                   | (use_ext & hs_fall & ~vs_in);
  assign cap_stop  = src_off | (use_embed & lead_byte) | (use_ext & hs_rise);

  vsd_pixel_pack #(.DATA_W(DATA_W)) pack_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .din    (din),
    .start  (cap_start),
    .stop   (cap_stop),
    .y_out  (y_out),
    .cb_out (cb_out),
    .cr_out (cr_out),
    .valid  (pix_valid)
  );

  // Timing flags: R3, R7, R9, R2
  tflags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (use_embed && code_hit) begin
      flags_d = code_flags;
    end else if (use_ext) begin
      flags_d.h = hs_in;
      flags_d.v = vs_in;
      flags_d.f = flags_q.f ^ vs_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign h_flag = flags_q.h;
  assign v_flag = flags_q.v;
  assign f_flag = flags_q.f;

endmodule

// File: rtl/vsd_demux_checker.sv
module vsd_demux_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        src_mode,
  input logic              pix_valid,
  input logic [DATA_W-1:0] y_out,
  input logic [DATA_W-1:0] cb_out,
  input logic [DATA_W-1:0] cr_out,
  input logic              h_flag,
  input logic              v_flag,
  input logic              f_flag
);

  assert_off_no_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !$past(src_mode[1]));

  assert_off_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_mode[1]) |-> ($stable(h_flag) && $stable(v_flag) && $stable(f_flag)));

  assert_pair_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |=> !pix_valid);

  assert_pair_shares_chroma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> ($stable(cb_out) && $stable(cr_out)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ($stable(y_out) && $stable(cb_out) && $stable(cr_out)));

endmodule

bind vid_stream_demux vsd_demux_checker #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_mode  (src_mode),
  .pix_valid (pix_valid),
  .y_out     (y_out),
  .cb_out    (cb_out),
  .cr_out    (cr_out),
  .h_flag    (h_flag),
  .v_flag    (v_flag),
  .f_flag    (f_flag)
);

// File: tb/vid_stream_demux_tb_top.sv
module vid_stream_demux_tb_top;

  // 50 MHz: 20 time units per period
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [7:0] din;
  logic [1:0] mode;
  logic       hs, vs;
  logic [7:0] y_out, cb_out, cr_out;
  logic       pix_valid, h_flag, v_flag, f_flag;

  vid_stream_demux dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .src_mode(mode), .hs_in(hs), .vs_in(vs),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .pix_valid(pix_valid),
    .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag)
  );

  int    checks = 0;
  int    errors = 0;
  int    npix   = 0;
  string cur_req = "R1";

  // Reference model state
  logic [7:0] hist[$];
  bit         m_act;
  int         m_ph;
  logic [7:0] m_cb, m_y0, ey, ecb, ecr;
  bit         ev, eh, evf, ef, phs, pvs;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(logic [7:0] b, bit h, bit v, logic [1:0] m);
    bit code, st, sp;
    code = (m == 2'b00) && hist[2] == 8'hFF && hist[1] == 8'h00 && hist[0] == 8'h00 && b[7];
    ev = 1'b0;
    if (code) begin
      eh = b[4]; evf = b[5]; ef = b[6];
    end else if (m == 2'b01) begin
      if (v && !pvs) ef = !ef;
      eh = h; evf = v;
    end
    st = (code && !b[4] && !b[5]) || (m == 2'b01 && phs && !h && !v);
    sp = m[1] || (m == 2'b00 && b == 8'hFF) || (m == 2'b01 && !phs && h);
    if (st) begin
      m_act = 1'b1; m_ph = 0;
    end else if (sp) begin
      m_act = 1'b0;
    end else if (m_act) begin
      case (m_ph)
        0: m_cb = b;
        1: m_y0 = b;
        2: begin ey = m_y0; ecb = m_cb; ecr = b; ev = 1'b1; end
        default: begin ey = b; ev = 1'b1; end
      endcase
      m_ph = (m_ph + 1) % 4;
    end
    hist.push_front(b);
    void'(hist.pop_back());
    phs = h;
    pvs = v;
  endtask

  task automatic compare_all(string req);
    chk(req, "y_out", y_out, ey);
    chk(req, "cb_out", cb_out, ecb);
    chk(req, "cr_out", cr_out, ecr);
    chk(req, "pix_valid", pix_valid, ev);
    chk(req, "h_flag", h_flag, eh);
    chk(req, "v_flag", v_flag, evf);
    chk(req, "f_flag", f_flag, ef);
  endtask

  // One byte per clock; entered and left at a falling edge.
  task automatic cyc(logic [7:0] b, bit h, bit v, logic [1:0] m);
    din = b; hs = h; vs = v; mode = m;
    @(posedge clk);
    model_step(b, h, v, m);
    #5;
    compare_all(cur_req);
    if (pix_valid) npix++;
    @(negedge clk);
  endtask

  task automatic code(logic [1:0] m, bit h, bit v, logic [7:0] st);
    cyc(8'hFF, h, v, m);
    cyc(8'h00, h, v, m);
    cyc(8'h00, h, v, m);
    cyc(st, h, v, m);
  endtask

  task automatic px(logic [1:0] m, bit h, bit v, logic [7:0] cb, logic [7:0] ya,
                    logic [7:0] cr, logic [7:0] yb);
    cyc(cb, h, v, m);
    cyc(ya, h, v, m);
    cyc(cr, h, v, m);
    cyc(yb, h, v, m);
  endtask

  task automatic blank(logic [1:0] m, bit h, bit v, int n);
    for (int i = 0; i < n; i++) cyc((i % 2 == 0) ? 8'h80 : 8'h10, h, v, m);
  endtask

  // Watchdog
  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = 8'h00; mode = 2'b10; hs = 1'b0; vs = 1'b0;
    hist = '{8'h00, 8'h00, 8'h00};
    m_act = 0; m_ph = 0; m_cb = 0; m_y0 = 0; ey = 0; ecb = 0; ecr = 0;
    ev = 0; eh = 0; evf = 0; ef = 0; phs = 0; pvs = 0;

    // R1: outputs zero during reset and during the release window
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (2) cyc(8'h00, 0, 0, 2'b10);

    // R3: end-of-line code sets H
    cur_req = "R3";
    code(2'b00, 0, 0, 8'h9D);
    chk("R3", "h after end code", h_flag, 1);
    blank(2'b00, 0, 0, 4);

    // R4, R5: full line of four groups
    cur_req = "R4";
    code(2'b00, 0, 0, 8'h80);
    chk("R4", "h after start code", h_flag, 0);
    cur_req = "R5";
    npix = 0;
    px(2'b00, 0, 0, 8'h40, 8'h20, 8'hC0, 8'h30);
    px(2'b00, 0, 0, 8'h55, 8'h66, 8'h77, 8'h88);
    px(2'b00, 0, 0, 8'h12, 8'hEB, 8'hF0, 8'h10);
    px(2'b00, 0, 0, 8'h01, 8'hFE, 8'h7F, 8'h81);
    chk("R5", "pixels in line", npix, 8);

    // R6: end code terminates, then a line cut mid-group
    cur_req = "R6";
    code(2'b00, 0, 0, 8'h9D);
    blank(2'b00, 0, 0, 2);
    code(2'b00, 0, 0, 8'h80);
    npix = 0;
    px(2'b00, 0, 0, 8'h21, 8'h31, 8'h41, 8'h51);
    cyc(8'h61, 0, 0, 2'b00);
    cyc(8'h71, 0, 0, 2'b00);
    code(2'b00, 0, 0, 8'h9D);
    chk("R6", "pixels in cut line", npix, 2);

    // R4: start code in vertical blanking opens nothing
    cur_req = "R4";
    code(2'b00, 0, 0, 8'hAB);
    chk("R4", "v after blanking start", v_flag, 1);
    npix = 0;
    px(2'b00, 0, 0, 8'h33, 8'h44, 8'h55, 8'h66);
    chk("R4", "no pixels in vertical blanking", npix, 0);
    code(2'b00, 0, 0, 8'hB6);

    // R3: status byte with bit 7 clear is ignored
    cur_req = "R3";
    code(2'b00, 0, 0, 8'h5A);
    chk("R3", "h kept on bad status", h_flag, 1);
    chk("R3", "f kept on bad status", f_flag, 0);
    npix = 0;
    px(2'b00, 0, 0, 8'h11, 8'h22, 8'h33, 8'h44);
    chk("R3", "no pixels after bad status", npix, 0);

    // R3: second field
    code(2'b00, 0, 0, 8'hC7);
    chk("R3", "f on second field", f_flag, 1);
    px(2'b00, 0, 0, 8'h9A, 8'h8B, 8'h7C, 8'h6D);
    code(2'b00, 0, 0, 8'hDA);

    // R2: off modes freeze flags and block pixels
    cur_req = "R2";
    npix = 0;
    code(2'b10, 0, 0, 8'h80);
    px(2'b10, 0, 0, 8'h23, 8'h45, 8'h67, 8'h89);
    code(2'b11, 1, 1, 8'h9D);
    px(2'b11, 1, 1, 8'h23, 8'h45, 8'h67, 8'h89);
    chk("R2", "no pixels when off", npix, 0);
    chk("R2", "h held when off", h_flag, 1);
    chk("R2", "f held when off", f_flag, 1);

    // R9: codes in the stream ignored in external mode
    cur_req = "R9";
    blank(2'b01, 1, 0, 3);
    code(2'b01, 1, 0, 8'h80);
    chk("R9", "h follows strobe not code", h_flag, 1);
    chk("R9", "f unchanged by code", f_flag, 1);

    // R8: horizontal strobe edges frame the line
    cur_req = "R8";
    npix = 0;
    cyc(8'h10, 0, 0, 2'b01);
    px(2'b01, 0, 0, 8'h70, 8'h60, 8'h90, 8'h50);
    px(2'b01, 0, 0, 8'h3C, 8'hA5, 8'hC3, 8'h5A);
    px(2'b01, 0, 0, 8'h0F, 8'hF0, 8'h1E, 8'hE1);
    cyc(8'h2D, 0, 0, 2'b01);
    cyc(8'hD2, 0, 0, 2'b01);
    cyc(8'h4B, 1, 0, 2'b01);
    chk("R8", "pixels in strobe line", npix, 6);
    blank(2'b01, 1, 0, 3);
    npix = 0;
    cyc(8'h10, 0, 0, 2'b01);
    px(2'b01, 0, 0, 8'h19, 8'h28, 8'h37, 8'h46);
    cyc(8'h80, 1, 0, 2'b01);
    chk("R8", "pixels in short strobe line", npix, 2);

    // R7: field toggles on vertical rise
    cur_req = "R7";
    cyc(8'h10, 1, 1, 2'b01);
    chk("R7", "f toggled", f_flag, 0);
    chk("R7", "v follows strobe", v_flag, 1);

    // R10: no capture while vertical strobe is high
    cur_req = "R10";
    npix = 0;
    cyc(8'h10, 0, 1, 2'b01);
    px(2'b01, 0, 1, 8'h64, 8'h73, 8'h82, 8'h91);
    chk("R10", "no pixels in vertical blanking", npix, 0);
    cyc(8'h10, 1, 1, 2'b01);
    cur_req = "R7";
    blank(2'b01, 1, 0, 2);
    cyc(8'h10, 1, 1, 2'b01);
    chk("R7", "f toggled back", f_flag, 1);
    blank(2'b01, 1, 1, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule